// File: doc/BRIEF.md
# Seven-slot LVDS pixel serializer

This block turns parallel pixels into serial LVDS-style lane streams. A pixel is captured when a pixel strobe is high. On a load strobe it is packed into one 7-bit word per data lane, and the words are shifted out one bit per bit-clock cycle. The block runs entirely on the 7x bit clock. The load strobe marks the start of each pixel-clock period, so one period spans seven bit-clock cycles.

The colour-depth setting picks the number of active data lanes: three for 18-bit colour, four for 24-bit and five for 30-bit. Lanes that the selected depth does not use stay low. Every link also carries a clock lane, which sends a fixed 7-bit pattern. In dual mode, captured pixels alternate between link A and link B. Each link then carries half the pixel rate, and both links load on the same strobe.

Within each word, slots leave in a fixed non-sequential order: word bit 1 first, then bit 0, then bits 6, 5, 4, 3 and 2. The first slot lines up with the rising edge of the clock-lane pattern.

Top module: `ldi_serializer`

## Requirements
- R1: After reset all lane outputs are low. The pixel holding registers are zero, so a load that follows reset with no pixel captured sends all-zero data words and the normal clock pattern on link A.
- R2: The bit-clock cycle after a load edge shows slot 0 of the new word. Word bit w goes out in slot s following the order bit1, bit0, bit6, bit5, bit4, bit3, bit2, one slot per bit-clock cycle.
- R3: Each active clock lane sends the word 7'b1100011, so the line reads 1,1,1,1,0,0,0 over the seven slots. Link A's clock lane is always active.
- R4: The 21 core bits fill data lanes 0 to 2, where lane L word bit k holds stream bit 7L+k. The stream is red[9:4] at bits 0 to 5, green[9:4] at 6 to 11, blue[9:4] at 12 to 17, then hsync at 18, vsync at 19 and data-enable at 20.
- R5: At 24-bit depth (depth code 2'b01), lane 3 carries {0, blue[3:2], green[3:2], red[3:2]} with red[2] at word bit 0. Lane 4 stays low.
- R6: At 30-bit depth (codes 2'b10 and 2'b11), lane 3 is filled as in R5. Lane 4 carries {0, blue[1:0], green[1:0], red[1:0]} with red[0] at word bit 0.
- R7: At 18-bit depth (code 2'b00), lanes 3 and 4 stay low on both links. Colour bits [3:0] have no effect.
- R8: Load strobes every seven bit-clock cycles produce an unbroken stream with no gap slot between words.
- R9: When no load follows a word, all lanes are low from the eighth slot after the load until the next load.
- R10: In single mode every captured pixel goes to link A, and all of link B, including its clock lane, is loaded with zeros.
- R11: In dual mode, captured pixels alternate between link A (even index) and link B (odd index). The index count restarts at zero whenever single mode is selected. Both links load on the same strobe, and each link carries its own clock pattern.
- R12: A pixel captured on a pixel-strobe edge is the one sent by the next load edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7x bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_i | input | 2 | Colour depth: 00=18, 01=24, 10/11=30 bit |
| dual_i | input | 1 | 1 = split pixels over two links |
| px_stb_i | input | 1 | Capture the pixel inputs on this edge |
| red_i | input | 10 | Red component |
| grn_i | input | 10 | Green component |
| blu_i | input | 10 | Blue component |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| ld_stb_i | input | 1 | Load strobe, start of a pixel-clock period |
| a_dat_o | output | 5 | Link A data lanes |
| a_clk_o | output | 1 | Link A clock lane |
| b_dat_o | output | 5 | Link B data lanes |
| b_clk_o | output | 1 | Link B clock lane |

## Verification
Several behaviours are checked on every cycle. The clock lane is high in the first slot after a load. A lane drains to zero once seven slots pass without a load. Link B is blanked in single mode, and the unused lanes are low at 18-bit depth. The pixel-index parity must flip on each capture in dual mode and hold at zero in single mode.

Other behaviours only the bench scenarios can show. These are the full slot order, the bit-to-lane packing at each depth, and the gapless chaining of words. They also include the even/odd assignment of pixels across the two links, and the one-period delay between capture and transmission.

// File: rtl/ldi_pkg.sv
package ldi_pkg;
  localparam int PIX_W  = 10;
  localparam int SLOT_N = 7;
  localparam int DLANES = 5;
  localparam int LINKS  = 2;
  localparam int FLAT_W = DLANES * SLOT_N;
  localparam logic [SLOT_N-1:0] CLK_WORD = 7'b1100011;

  typedef enum logic [1:0] {
    DEPTH18  = 2'b00,
    DEPTH24  = 2'b01,
    DEPTH30  = 2'b10,
    DEPTH30X = 2'b11
  } depth_e;

  typedef struct packed {
    logic [PIX_W-1:0] r;
    logic [PIX_W-1:0] g;
    logic [PIX_W-1:0] b;
    logic             hs;
    logic             vs;
    logic             de;
  } pix_t;

  // Lane words for one pixel, lane L at bits [L*SLOT_N +: SLOT_N].
  function automatic logic [FLAT_W-1:0] pack_pixel(pix_t p, depth_e d);
    logic [FLAT_W-1:0] s;
    s = '0;
    s[20:0] = {p.de, p.vs, p.hs, p.b[PIX_W-1 -: 6], p.g[PIX_W-1 -: 6], p.r[PIX_W-1 -: 6]};
    if (d != DEPTH18)
      s[27:21] = {1'b0, p.b[PIX_W-7 -: 2], p.g[PIX_W-7 -: 2], p.r[PIX_W-7 -: 2]};
    if (d == DEPTH30 || d == DEPTH30X)
      s[34:28] = {1'b0, p.b[1:0], p.g[1:0], p.r[1:0]};
    return s;
  endfunction

  // Reorder a word so that bit 0 of the result is the first slot on the line.
  function automatic logic [SLOT_N-1:0] slot_order(logic [SLOT_N-1:0] w);
    return {w[2], w[3], w[4], w[5], w[6], w[0], w[1]};
  endfunction
endpackage

// File: rtl/ldi_pix_capture.sv
module ldi_pix_capture
  import ldi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dual_i,
  input  logic stb_i,
  input  pix_t pix_i,
  output pix_t hold_a_o,
  output pix_t hold_b_o,
  output logic par_o
);
  pix_t hold_a_q, hold_b_q;
  logic par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
      par_q    <= 1'b0;
    end else begin
      if (stb_i) begin
        if (dual_i && par_q) hold_b_q <= pix_i;
        else                 hold_a_q <= pix_i;
      end
      par_q <= dual_i ? (par_q ^ stb_i) : 1'b0;
    end
  end

  assign hold_a_o = hold_a_q;
  assign hold_b_o = hold_b_q;
  assign par_o    = par_q;

  p_par_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_i && stb_i) |=> (par_q != $past(par_q)));
  p_par_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_i |=> !par_q);
endmodule

// File: rtl/ldi_lane_ser.sv
module ldi_lane_ser #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] word_i,
  output logic         ser_o
);
  import ldi_pkg::slot_order;
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      since_q <= CW'(W);
    end else if (ld_i) begin
      sh_q    <= slot_order(word_i);
      since_q <= '0;
    end else begin
      sh_q <= sh_q >> 1;
      if (since_q != CW'(W)) since_q <= since_q + 1'b1;
    end
  end

  assign ser_o = sh_q[0];

  p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (ser_o == $past(word_i[1])));
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == CW'(W)) |-> !ser_o);
endmodule

// File: rtl/ldi_serializer.sv
module ldi_serializer
  import ldi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  depth_i,
  input  logic        dual_i,
  input  logic        px_stb_i,
  input  logic [9:0]  red_i,
  input  logic [9:0]  grn_i,
  input  logic [9:0]  blu_i,
  input  logic        hs_i,
  input  logic        vs_i,
  input  logic        de_i,
  input  logic        ld_stb_i,
  output logic [4:0]  a_dat_o,
  output logic        a_clk_o,
  output logic [4:0]  b_dat_o,
  output logic        b_clk_o
);
  pix_t   pix_in, hold_a, hold_b;
  logic   par;
  depth_e dep;
  logic [FLAT_W-1:0] link_flat [LINKS];
  logic [SLOT_N-1:0] clk_word  [LINKS];
  logic              ser_bits  [LINKS][DLANES+1];

  assign pix_in = '{r: red_i, g: grn_i, b: blu_i, hs: hs_i, vs: vs_i, de: de_i};
  assign dep    = depth_e'(depth_i);

  ldi_pix_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual_i   (dual_i),
    .stb_i    (px_stb_i),
    .pix_i    (pix_in),
    .hold_a_o (hold_a),
    .hold_b_o (hold_b),
    .par_o    (par)
  );

  always_comb begin
    link_flat[0] = pack_pixel(hold_a, dep);
    link_flat[1] = dual_i ? pack_pixel(hold_b, dep) : '0;
    clk_word[0]  = CLK_WORD;
    clk_word[1]  = dual_i ? CLK_WORD : '0;
  end

  for (genvar k = 0; k < LINKS; k++) begin : g_link
    for (genvar l = 0; l <= DLANES; l++) begin : g_lane
      logic [SLOT_N-1:0] w;
      if (l < DLANES) begin : g_dat
        assign w = link_flat[k][l*SLOT_N +: SLOT_N];
      end else begin : g_clk
        assign w = clk_word[k];
      end
      ldi_lane_ser #(.W(SLOT_N)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (ld_stb_i),
        .word_i (w),
        .ser_o  (ser_bits[k][l])
      );
    end
  end

  always_comb begin
    for (int l = 0; l < DLANES; l++) begin
      a_dat_o[l] = ser_bits[0][l];
      b_dat_o[l] = ser_bits[1][l];
    end
    a_clk_o = ser_bits[0][DLANES];
    b_clk_o = ser_bits[1][DLANES];
  end

  p_clk_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb_i |=> a_clk_o);
  p_b_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb_i && !dual_i) |=> (b_dat_o == 5'd0 && !b_clk_o));
  p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb_i && depth_i == 2'b00) |=> (a_dat_o[4:3] == 2'd0 && b_dat_o[4:3] == 2'd0));
  p_par_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(par));
endmodule

// File: tb/ldi_serializer_bench.sv
`timescale 1ns/1ps
module ldi_serializer_bench;
  typedef struct packed {
    logic [9:0] r; logic [9:0] g; logic [9:0] b;
    logic hs; logic vs; logic de;
  } bpix_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] depth_i = 2'b00;
  logic dual_i = 1'b0, px_stb_i = 1'b0, ld_stb_i = 1'b0;
  logic [9:0] red_i = '0, grn_i = '0, blu_i = '0;
  logic hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
  logic [4:0] a_dat_o, b_dat_o;
  logic a_clk_o, b_clk_o;

  always #2.5 clk = ~clk;

  ldi_serializer u_ldi_serializer (
    .clk(clk), .rst_n(rst_n), .depth_i(depth_i), .dual_i(dual_i),
    .px_stb_i(px_stb_i), .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i), .ld_stb_i(ld_stb_i),
    .a_dat_o(a_dat_o), .a_clk_o(a_clk_o), .b_dat_o(b_dat_o), .b_clk_o(b_clk_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int ORD [7] = '{1, 0, 6, 5, 4, 3, 2};
  logic [6:0] got  [2][6];   // per link, lane 0..4 data, 5 clock; index = slot
  logic [6:0] expw [2][6];   // expected words, index = word bit
  bpix_t held_a = '0, held_b = '0;
  int pix_idx = 0;

  function automatic logic [34:0] stream_of(bpix_t p, logic [1:0] d);
    logic [34:0] s; int n;
    s = '0; n = 0;
    for (int i = 4; i < 10; i++) begin s[n] = p.r[i]; n++; end
    for (int i = 4; i < 10; i++) begin s[n] = p.g[i]; n++; end
    for (int i = 4; i < 10; i++) begin s[n] = p.b[i]; n++; end
    s[n] = p.hs; n++; s[n] = p.vs; n++; s[n] = p.de; n++;
    if (d != 2'b00) begin
      for (int i = 2; i < 4; i++) begin s[n] = p.r[i]; n++; end
      for (int i = 2; i < 4; i++) begin s[n] = p.g[i]; n++; end
      for (int i = 2; i < 4; i++) begin s[n] = p.b[i]; n++; end
      n++;
    end
    if (d[1]) begin
      for (int i = 0; i < 2; i++) begin s[n] = p.r[i]; n++; end
      for (int i = 0; i < 2; i++) begin s[n] = p.g[i]; n++; end
      for (int i = 0; i < 2; i++) begin s[n] = p.b[i]; n++; end
    end
    return s;
  endfunction

  function automatic bpix_t mkpix(int i);
    bpix_t p;
    p.r = 10'(i * 97 + 13); p.g = 10'(i * 211 + 5); p.b = 10'(i * 331 + 700);
    p.hs = i[0]; p.vs = i[1]; p.de = ~i[2];
    return p;
  endfunction

  task automatic fill_exp(int k, bpix_t p, logic [1:0] d, bit on);
    logic [34:0] s;
    s = stream_of(p, d);
    for (int l = 0; l < 5; l++) expw[k][l] = on ? s[l*7 +: 7] : 7'd0;
    expw[k][5] = on ? 7'b1100011 : 7'd0;
  endtask

  task automatic check_link(int k, string tag);
    int bad;
    logic [6:0] ev;
    bad = -1;
    checks++;
    for (int l = 0; l < 6; l++) begin
      for (int s = 0; s < 7; s++) ev[s] = expw[k][l][ORD[s]];
      if (bad < 0 && got[k][l] !== ev) begin
        bad = l;
        fails++;
        $display("FAIL %s link %0d lane %0d slots actual=%b expected=%b", tag, k, l, got[k][l], ev);
      end
    end
  endtask

  // Load held pixels, sample seven slots, capture up to two new pixels (R12).
  task automatic run_word(bpix_t p0, bit send0, bpix_t p1, bit send1);
    ld_stb_i = 1'b1;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      for (int l = 0; l < 5; l++) begin
        got[0][l][s] = a_dat_o[l];
        got[1][l][s] = b_dat_o[l];
      end
      got[0][5][s] = a_clk_o;
      got[1][5][s] = b_clk_o;
      if (s == 0) ld_stb_i = 1'b0;
      px_stb_i = 1'b0;
      if ((s == 0 && send0) || (s == 2 && send1)) begin
        bpix_t p;
        p = (s == 0) ? p0 : p1;
        {red_i, grn_i, blu_i, hs_i, vs_i, de_i} = p;
        px_stb_i = 1'b1;
      end
    end
  endtask

  task automatic word_and_check(bpix_t p0, bit send0, bpix_t p1, bit send1, string tag);
    fill_exp(0, held_a, depth_i, 1'b1);
    fill_exp(1, held_b, depth_i, dual_i);
    run_word(p0, send0, p1, send1);
    check_link(0, tag);
    check_link(1, tag);
    if (dual_i) begin
      if (send0) begin if (pix_idx % 2 == 0) held_a = p0; else held_b = p0; pix_idx++; end
      if (send1) begin if (pix_idx % 2 == 0) held_a = p1; else held_b = p1; pix_idx++; end
    end else begin
      pix_idx = 0;
      if (send0) held_a = p0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    checks++;
    if ({a_dat_o, a_clk_o, b_dat_o, b_clk_o} !== 12'd0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b expected=0", {a_dat_o, a_clk_o, b_dat_o, b_clk_o});
    end
    word_and_check('0, 1'b0, '0, 1'b0, "R1 zero hold after reset R3");
  endtask

  task automatic t_single(logic [1:0] d, int base, string tag);
    depth_i = d; dual_i = 1'b0;
    for (int i = 0; i < 4; i++)   // back-to-back words, R8 and R2
      word_and_check(mkpix(base + i), 1'b1, '0, 1'b0, tag);
  endtask

  task automatic t_dual(logic [1:0] d, int base);
    depth_i = d; dual_i = 1'b1;
    for (int i = 0; i < 4; i++)
      word_and_check(mkpix(base + 2*i), 1'b1, mkpix(base + 2*i + 1), 1'b1, "R11 dual split R3");
  endtask

  task automatic t_idle;
    word_and_check(mkpix(77), 1'b1, '0, 1'b0, "R9 last word");
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      checks++;
      if ({a_dat_o, a_clk_o, b_dat_o, b_clk_o} !== 12'd0) begin
        fails++;
        $display("FAIL R9 idle slot %0d actual=%b expected=0", s + 7, {a_dat_o, a_clk_o, b_dat_o, b_clk_o});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single(2'b01, 1, "R4 R5 24-bit R2 R10 R12");
    t_single(2'b00, 10, "R7 18-bit R4");
    t_single(2'b10, 20, "R6 30-bit");
    t_single(2'b11, 30, "R6 code 11");
    t_dual(2'b01, 40);
    t_dual(2'b00, 60);
    dual_i = 1'b0;
    t_single(2'b10, 80, "R10 back to single");
    t_idle;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule